// File: doc/BRIEF.md
# Coprocessor Response Primitive Sequencer

This block runs on the main-processor side of a coprocessor link and steps through the response primitives for one coprocessor instruction. A `start` pulse loads the address of the instruction's operation word. The sequencer then fetches 16-bit primitives from the coprocessor's response register over a simple request/acknowledge register port. For each primitive it decodes the option bits and the function and parameter fields. When a primitive asks for it, the sequencer first writes the saved instruction address to the coprocessor's instruction-address register.

After that optional write, the sequencer carries out the primitive. A transfer service appears as a one-cycle pulse carrying the decoded parameter and direction. A null primitive only ends the instruction or keeps the chain going. A primitive that asks for an exception, or that carries an unknown function code, becomes a one-cycle trap request with a kind code. When the come-again bit is set, the sequencer reads the response register again. A chain-length limit stops a coprocessor that never ends its chain.

Primitive word layout: bit 15 is come-again, bit 14 is pass-address, bit 13 is direction, bits 12..8 are the function code and bits 7..0 are the parameter. The function codes are 0 (null), 1 (transfer) and 2 (take exception). Every other code is undefined.

Top module: `cp_resp_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `bus_req`, `svc_valid`, `done` and `trap_valid` are all 0.
- R2: A `start` pulse while idle is followed by a read request to the response register (`bus_req`=1, `bus_we`=0, `bus_sel`=0).
- R3: If bit 14 of a primitive is 1, exactly one write (`bus_we`=1, `bus_sel`=1) of the address captured at `start` is made before that primitive is acted on. If bit 14 is 0, no write is made for that primitive.
- R4: A primitive with function code 1 produces exactly one `svc_valid` pulse, with `svc_func`=1, `svc_param` equal to bits 7..0 and `svc_dir` equal to bit 13.
- R5: If bit 15 of a defined non-exception primitive is 1, the response register is read again and the next primitive is processed. Each primitive in a chain costs exactly one read.
- R6: A null (code 0) or transfer (code 1) primitive with bit 15 clear ends the instruction with a single `done` pulse and a return to idle. A null primitive produces no service pulse.
- R7: A primitive with an undefined function code (3..31) raises one `trap_valid` pulse with `trap_kind`=1 (protocol violation). It produces no `done` and no service pulse.
- R8: A primitive with function code 2 raises one `trap_valid` pulse with `trap_kind`=0 (emulator trap) and no `done`.
- R9: On a trapping primitive with bit 14 set, the instruction-address write completes in an earlier cycle than the trap pulse.
- R10: If the MAX_CHAIN-th primitive of an instruction still has bit 15 set, its service is performed and then a protocol-violation trap (`trap_kind`=1) is raised instead of another read. No more than MAX_CHAIN reads happen per instruction.
- R11: An outstanding request holds `bus_req`, `bus_we`, `bus_sel` and `bus_wdata` steady until `bus_ack` is seen.
- R12: A `start` pulse while busy is ignored: the address passed stays the one captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a coprocessor instruction |
| start_addr | input | AW | Address of the instruction's operation word |
| busy | output | 1 | Sequence in progress |
| bus_req | output | 1 | Register port request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 1 | 0 = response register, 1 = instruction-address register |
| bus_wdata | output | AW | Write data (instruction address) |
| bus_ack | input | 1 | Request completes this cycle |
| bus_rdata | input | 16 | Primitive word, valid with `bus_ack` on a read |
| svc_valid | output | 1 | One-cycle service pulse |
| svc_func | output | 5 | Function code of the serviced primitive |
| svc_param | output | 8 | Parameter field of the serviced primitive |
| svc_dir | output | 1 | Direction flag of the serviced primitive |
| done | output | 1 | One-cycle instruction-complete pulse |
| trap_valid | output | 1 | One-cycle exception request |
| trap_kind | output | 1 | 0 = emulator trap, 1 = protocol violation |

## Verification
The bench builds the sequencer with AW=32 and MAX_CHAIN=3. A chain of four come-again primitives therefore reaches the chain limit in a few cycles, and a legal three-primitive chain runs right up to the limit without tripping it. The bench's coprocessor model can hold back its acknowledge. This exposes the request-stability rule and lets a second `start` arrive while the block is busy.

// File: rtl/cp_resp_seq.sv
module cp_resp_seq #(
  parameter int AW        = 32,
  parameter int MAX_CHAIN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_sel,
  output logic [AW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [15:0]   bus_rdata,
  output logic          svc_valid,
  output logic [4:0]    svc_func,
  output logic [7:0]    svc_param,
  output logic          svc_dir,
  output logic          done,
  output logic          trap_valid,
  output logic          trap_kind
);
  localparam int CW = $clog2(MAX_CHAIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAX_CHAIN);
  localparam logic [4:0] FN_NULL = 5'd0;
  localparam logic [4:0] FN_XFER = 5'd1;
  localparam logic [4:0] FN_TRAP = 5'd2;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_PASS, S_ACT} st_t;

  st_t           st;
  logic [15:0]   prim;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt;

  wire       ca      = prim[15];
  wire [4:0] fn      = prim[12:8];
  wire       is_trap = (fn == FN_TRAP);
  wire       defd    = (fn == FN_NULL) || (fn == FN_XFER) || is_trap;
  wire       act     = (st == S_ACT);
  wire       keep_on = defd && !is_trap && ca;
  wire       over    = keep_on && (cnt == CMAX);

  assign busy       = (st != S_IDLE);
  assign bus_req    = (st == S_READ) || (st == S_PASS);
  assign bus_we     = (st == S_PASS);
  assign bus_sel    = (st == S_PASS);
  assign bus_wdata  = addr;
  assign svc_valid  = act && (fn == FN_XFER);
  assign svc_func   = fn;
  assign svc_param  = prim[7:0];
  assign svc_dir    = prim[13];
  assign done       = act && defd && !is_trap && !ca;
  assign trap_valid = act && (!defd || is_trap || over);
  assign trap_kind  = !(defd && is_trap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      prim <= '0;
      addr <= '0;
      cnt  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          addr <= start_addr;
          cnt  <= '0;
          st   <= S_READ;
        end
        S_READ: if (bus_ack) begin
          prim <= bus_rdata;
          cnt  <= cnt + 1'b1;
          st   <= bus_rdata[14] ? S_PASS : S_ACT;
        end
        S_PASS: if (bus_ack) st <= S_ACT;
        S_ACT:  st <= (keep_on && !over) ? S_READ : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cp_resp_seq_chk.sv
module cp_resp_seq_chk #(
  parameter int AW        = 32,
  parameter int MAX_CHAIN = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_sel,
  input logic [AW-1:0] bus_wdata,
  input logic          bus_ack,
  input logic          svc_valid,
  input logic          done,
  input logic          trap_valid
);
  logic [15:0] rd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_seen <= '0;
    else if (start && !busy) rd_seen <= '0;
    else if (bus_req && bus_ack && !bus_we) rd_seen <= rd_seen + 1'b1;
  end

  assert_start_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_req && !bus_we && !bus_sel));

  assert_write_targets_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> bus_sel);

  assert_done_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_trap_excl_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (!done && $onehot0({trap_valid, done})));

  assert_chain_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_seen <= 16'(MAX_CHAIN));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_sel) && $stable(bus_wdata)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !svc_valid && !done && !trap_valid));
endmodule

bind cp_resp_seq cp_resp_seq_chk #(.AW(AW), .MAX_CHAIN(MAX_CHAIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .bus_req(bus_req),
  .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .svc_valid(svc_valid), .done(done), .trap_valid(trap_valid)
);

// File: tb/cp_resp_seq_bench.sv
module cp_resp_seq_bench;
  localparam int AW = 32;
  localparam int MC = 3;

  logic clk = 0, rst_n = 0, start = 0, bus_ack, ack_en = 1, clr = 0;
  logic [AW-1:0] start_addr = '0, bus_wdata;
  logic busy, bus_req, bus_we, bus_sel, svc_valid, svc_dir, done, trap_valid, trap_kind;
  logic [4:0] svc_func;
  logic [7:0] svc_param;
  logic [15:0] bus_rdata;
  logic [15:0] prims [0:7];

  int total = 0, bad = 0, cyc = 0;
  int rd_ptr, n_rd, n_wr, n_svc, n_done, n_trap, wr_cyc, trap_cyc;
  logic [AW-1:0] wr_last;
  logic [7:0] l_param;
  logic [4:0] l_func;
  logic l_dir, l_kind;

  always #4 clk = ~clk;

  cp_resp_seq #(.AW(AW), .MAX_CHAIN(MC)) u_cp_resp_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .svc_valid(svc_valid), .svc_func(svc_func),
    .svc_param(svc_param), .svc_dir(svc_dir), .done(done), .trap_valid(trap_valid),
    .trap_kind(trap_kind));

  assign bus_ack   = bus_req && ack_en;
  assign bus_rdata = prims[rd_ptr[2:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      rd_ptr <= 0; n_rd <= 0; n_wr <= 0; n_svc <= 0; n_done <= 0; n_trap <= 0;
      wr_cyc <= 0; trap_cyc <= 0; wr_last <= '0; l_param <= '0; l_func <= '0;
      l_dir <= 0; l_kind <= 0;
    end else begin
      if (bus_req && bus_ack && !bus_we) begin rd_ptr <= rd_ptr + 1; n_rd <= n_rd + 1; end
      if (bus_req && bus_ack && bus_we) begin n_wr <= n_wr + 1; wr_last <= bus_wdata; wr_cyc <= cyc; end
      if (svc_valid) begin n_svc <= n_svc + 1; l_param <= svc_param; l_func <= svc_func; l_dir <= svc_dir; end
      if (done) n_done <= n_done + 1;
      if (trap_valid) begin n_trap <= n_trap + 1; l_kind <= trap_kind; trap_cyc <= cyc; end
    end
    if (cyc > 20000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic clear_log();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic pulse_start(input logic [AW-1:0] a);
    @(negedge clk); start = 1; start_addr = a;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 60 && (n_done + n_trap) == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !bus_req && !svc_valid && !done && !trap_valid, "R1 reset idle",
        {busy, bus_req, svc_valid, done, trap_valid}, 0);
  endtask

  task automatic t_single_xfer();
    clear_log();
    prims[0] = 16'h215A;
    pulse_start(32'h0000_1000);
    chk(bus_req && !bus_we && !bus_sel, "R2 read issued", {bus_req, bus_we, bus_sel}, 3'b100);
    wait_end();
    chk(n_rd == 1 && n_wr == 0, "R3 no write without bit14", n_wr, 0);
    chk(n_svc == 1 && l_func == 1 && l_param == 8'h5A && l_dir == 1, "R4 service fields",
        {l_func, l_param, l_dir}, {5'd1, 8'h5A, 1'b1});
    chk(n_done == 1 && n_trap == 0 && !busy, "R6 done after xfer", n_done, 1);
  endtask

  task automatic t_pass_null();
    clear_log();
    prims[0] = 16'h4000;
    pulse_start(32'hCAFE_0010);
    wait_end();
    chk(n_wr == 1 && wr_last == 32'hCAFE_0010, "R3 address passed", wr_last, 32'hCAFE_0010);
    chk(n_svc == 0 && n_done == 1, "R6 null gives done only", n_svc, 0);
  endtask

  task automatic t_chain();
    clear_log();
    prims[0] = 16'h8133; prims[1] = 16'hC000; prims[2] = 16'h0177;
    pulse_start(32'h0000_2000);
    wait_end();
    chk(n_rd == 3 && n_wr == 1, "R5 chain reads", n_rd, 3);
    chk(n_svc == 2 && l_param == 8'h77 && l_dir == 0, "R5 chain services", {n_svc[7:0], l_param}, {8'd2, 8'h77});
    chk(n_done == 1 && n_trap == 0, "R10 legal chain at limit", n_trap, 0);
  endtask

  task automatic t_undef();
    clear_log();
    prims[0] = 16'h4700;
    pulse_start(32'h0000_3000);
    wait_end();
    chk(n_trap == 1 && l_kind == 1 && n_done == 0 && n_svc == 0, "R7 undefined -> protocol",
        {n_trap[3:0], l_kind, n_done[3:0]}, {4'd1, 1'b1, 4'd0});
    chk(n_wr == 1 && wr_last == 32'h0000_3000 && wr_cyc < trap_cyc, "R9 write before trap", wr_cyc, trap_cyc);
  endtask

  task automatic t_take_exc();
    clear_log();
    prims[0] = 16'h0205;
    pulse_start(32'h0000_4000);
    wait_end();
    chk(n_trap == 1 && l_kind == 0 && n_done == 0, "R8 emulator trap", {n_trap[3:0], l_kind}, {4'd1, 1'b0});
  endtask

  task automatic t_watchdog();
    clear_log();
    for (int i = 0; i < 8; i++) prims[i] = 16'h8100;
    pulse_start(32'h0000_5000);
    wait_end();
    chk(n_rd == MC && n_svc == MC, "R10 reads capped", n_rd, MC);
    chk(n_trap == 1 && l_kind == 1 && n_done == 0, "R10 protocol trap", {n_trap[3:0], l_kind}, {4'd1, 1'b1});
  endtask

  task automatic t_stall();
    clear_log();
    ack_en = 0;
    prims[0] = 16'h0111;
    pulse_start(32'h0000_6000);
    repeat (5) @(negedge clk);
    chk(bus_req && !bus_we && !bus_sel && n_svc == 0, "R11 request held", {bus_req, bus_we, bus_sel}, 3'b100);
    ack_en = 1;
    wait_end();
    chk(n_svc == 1 && l_param == 8'h11 && n_done == 1, "R11 completes after ack", l_param, 8'h11);
  endtask

  task automatic t_busy_start();
    clear_log();
    ack_en = 0;
    prims[0] = 16'h4000;
    pulse_start(32'h0000_A000);
    repeat (2) @(negedge clk);
    pulse_start(32'h0000_B000);
    repeat (2) @(negedge clk);
    ack_en = 1;
    wait_end();
    chk(n_wr == 1 && wr_last == 32'h0000_A000, "R12 start ignored while busy", wr_last, 32'h0000_A000);
    chk(n_rd == 1 && n_done == 1 && !busy, "R12 single run", n_rd, 1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) prims[i] = '0;
    clr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; clr = 0;
    @(negedge clk);
    t_reset();
    t_single_xfer();
    t_pass_null();
    t_chain();
    t_undef();
    t_take_exc();
    t_watchdog();
    t_stall();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule